// File: doc/BRIEF.md
# Shadow-Swap Serial Shift Slice

This block is one serial shift lane of a parallel-to-serial and serial-to-parallel engine. A 32-bit working register shifts one bit per strike: the serial input enters at the MSB and the LSB drives the serial output. A programmable down-counter divides the system clock to produce the strikes. A second down-counter counts strikes. Each time it reaches zero, the working register and a shadow register trade contents. The word that has just been shifted in lands in the shadow register, where software can read it. The word that software placed in the shadow register becomes the next word to shift out.

The lane can also act as a pattern detector. When pattern-match operation is selected and the match event is enabled, the shadow register holds a reference word and stops taking part in exchanges. The working register is compared against it every cycle, with an optional per-bit don't-care mask. A single-cycle event marks each moment the comparison starts to hold. Three single-cycle strobes (shift, swap and match) are meant to feed an interrupt controller.

Top module: `shadow_shift_slice`

## Requirements
- R1: While `rstN` is low, `serOut`, `shiftEvt`, `swapEvt`, `matchEvt` and `shadowRdData` are all 0, and both counters are cleared.
- R2: While `enable` is high, a strike occurs on the first enabled clock edge and then once every `divPreset`+1 enabled edges. Each strike produces a one-cycle `shiftEvt` pulse in the cycle after that edge. While `enable` is low, no strike and no `shiftEvt` occur.
- R3: On each strike the working register moves right by one bit: `serIn` enters bit 31 and `serOut` always shows bit 0. `serOut` changes only in a cycle in which `shiftEvt` is high.
- R4: The position counter decrements on each strike. A strike that finds it at zero performs an exchange and reloads the counter with `posPreset`, so exchanges happen on the first strike after reset and then every `posPreset`+1 strikes. Each exchange raises a one-cycle `swapEvt` together with `shiftEvt`.
- R5: On an exchange, the working register takes the previous shadow contents. The shadow register takes the working word shifted by that strike, `serIn` included. With `posPreset`=31, the shadow captures the 32 bits fed since the previous exchange, with the earliest bit at bit 0.
- R6: A high `shadowWrEn` loads `shadowWrData` into the shadow register at the clock edge, and `shadowRdData` shows it from the next cycle on. A write on the same edge as an exchange takes priority over the exchange's capture into the shadow register.
- R7: Pattern-match operation is active only while both `matchModeCfg` and `matchIrqEn` are high. With either one low, exchanges continue normally and `matchEvt` stays 0.
- R8: While pattern-match operation is active, no exchange takes place, `swapEvt` stays 0 and the shadow register keeps its pattern. Shifting continues.
- R9: While active, `matchEvt` pulses for one cycle, one clock edge after the masked comparison between the working and shadow registers becomes true. A comparison that stays true gives no further pulse.
- R10: With `HAS_MASK`=1, a 1 in bit i of `patternMask` removes bit i from the comparison. A 0 bit requires the two registers to agree at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets the clock divider run |
| divPreset | input | DIV_W | Divider reload value; strike period is divPreset+1 |
| posPreset | input | POS_W | Position counter reload value; exchange period is posPreset+1 strikes |
| matchModeCfg | input | 1 | Selects pattern-match operation |
| matchIrqEn | input | 1 | Match event enable; also needed for pattern-match operation |
| patternMask | input | WIDTH | Per-bit don't-care for the comparison (1 = ignore) |
| serIn | input | 1 | Serial data into the MSB |
| serOut | output | 1 | Serial data from the LSB |
| shadowWrEn | input | 1 | Shadow register load strobe |
| shadowWrData | input | WIDTH | Shadow register load value |
| shadowRdData | output | WIDTH | Shadow register contents |
| shiftEvt | output | 1 | One-cycle pulse per strike |
| swapEvt | output | 1 | One-cycle pulse per exchange |
| matchEvt | output | 1 | One-cycle pulse on the rise of the comparison |

## Verification
A divider that reloads with the wrong value shows up at once as the wrong spacing between `shiftEvt` pulses. A slipped position counter moves the `swapEvt` pulse and corrupts the captured word that `shadowRdData` returns at the end of a 32-strike frame. Errors in shift direction or exchange routing appear on `serOut` one strike after they happen. A stale comparison history shows up within one cycle as a missing or repeated `matchEvt`. An exchange that escapes in match mode alters `shadowRdData` on the next strike.

// File: rtl/slice_pkg.sv
package slice_pkg;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic shift;  // strike: move one bit
    logic swap;   // exchange working and shadow registers
  } sliceStrobe_t;

endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divPreset,
  input  logic [POS_W-1:0] posPreset,
  input  logic             matchActive,
  output sliceStrobe_t     strobe
);

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] posCnt;
  logic             divZero;
  logic             posZero;

  assign divZero = (divCnt == '0);
  assign posZero = (posCnt == '0);

  // Clock divider: strike on zero, then reload from the preset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (enable) begin
      if (divZero) divCnt <= divPreset;
      else         divCnt <= divCnt - 1'b1;
    end
  end

  // Position counter: advances once per strike
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt <= '0;
    end else if (enable && divZero) begin
      if (posZero) posCnt <= posPreset;
      else         posCnt <= posCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.shift = enable && divZero;
    strobe.swap  = enable && divZero && posZero && !matchActive;
  end

endmodule

// File: rtl/slice_dp.sv
module slice_dp
  import slice_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit HAS_MASK = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sliceStrobe_t     strobe,
  input  logic             matchActive,
  input  logic             serIn,
  input  logic             shadowWrEn,
  input  logic [WIDTH-1:0] shadowWrData,
  input  logic [WIDTH-1:0] patternMask,
  output logic             serOut,
  output logic [WIDTH-1:0] shadowRdData,
  output logic             shiftEvt,
  output logic             swapEvt,
  output logic             matchEvt
);

  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] shadowReg;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] careBits;
  logic             cmpNow;
  logic             cmpQ;

  assign shifted = {serIn, dataReg[WIDTH-1:1]};

  // Working register: an exchange overrides the plain shift
  always_ff @(posedge clk) begin
    if (!rstN)            dataReg <= '0;
    else if (strobe.swap) dataReg <= shadowReg;
    else if (strobe.shift) dataReg <= shifted;
  end

  // Shadow register: a software write wins over the exchange capture
  always_ff @(posedge clk) begin
    if (!rstN)            shadowReg <= '0;
    else if (shadowWrEn)  shadowReg <= shadowWrData;
    else if (strobe.swap) shadowReg <= shifted;
  end

  generate
    if (HAS_MASK) begin : g_mask
      assign careBits = ~patternMask;
    end else begin : g_nomask
      assign careBits = '1;
    end
  endgenerate

  assign cmpNow = (((dataReg ^ shadowReg) & careBits) == '0);

  // Event strobes and compare history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftEvt <= 1'b0;
      swapEvt  <= 1'b0;
      matchEvt <= 1'b0;
      cmpQ     <= 1'b0;
    end else begin
      shiftEvt <= strobe.shift;
      swapEvt  <= strobe.swap;
      matchEvt <= matchActive && cmpNow && !cmpQ;
      cmpQ     <= matchActive && cmpNow;
    end
  end

  assign serOut       = dataReg[0];
  assign shadowRdData = shadowReg;

endmodule

// File: rtl/shadow_shift_slice.sv
module shadow_shift_slice
  import slice_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int DIV_W    = 12,
  parameter bit HAS_MASK = 1'b1,
  localparam int POS_W   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divPreset,
  input  logic [POS_W-1:0] posPreset,
  input  logic             matchModeCfg,
  input  logic             matchIrqEn,
  input  logic [WIDTH-1:0] patternMask,
  input  logic             serIn,
  output logic             serOut,
  input  logic             shadowWrEn,
  input  logic [WIDTH-1:0] shadowWrData,
  output logic [WIDTH-1:0] shadowRdData,
  output logic             shiftEvt,
  output logic             swapEvt,
  output logic             matchEvt
);

  sliceStrobe_t strobe;
  logic         matchActive;

  assign matchActive = matchModeCfg && matchIrqEn;

  slice_ctrl #(
    .DIV_W(DIV_W),
    .POS_W(POS_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .divPreset  (divPreset),
    .posPreset  (posPreset),
    .matchActive(matchActive),
    .strobe     (strobe)
  );

  slice_dp #(
    .WIDTH   (WIDTH),
    .HAS_MASK(HAS_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .matchActive (matchActive),
    .serIn       (serIn),
    .shadowWrEn  (shadowWrEn),
    .shadowWrData(shadowWrData),
    .patternMask (patternMask),
    .serOut      (serOut),
    .shadowRdData(shadowRdData),
    .shiftEvt    (shiftEvt),
    .swapEvt     (swapEvt),
    .matchEvt    (matchEvt)
  );

endmodule

// File: rtl/slice_chk.sv
module slice_chk #(
  parameter int WIDTH  = 32,
  parameter int DIV_W  = 12,
  localparam int POS_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [DIV_W-1:0] divPreset,
  input logic [POS_W-1:0] posPreset,
  input logic             matchModeCfg,
  input logic             matchIrqEn,
  input logic [WIDTH-1:0] patternMask,
  input logic             serIn,
  input logic             serOut,
  input logic             shadowWrEn,
  input logic [WIDTH-1:0] shadowWrData,
  input logic [WIDTH-1:0] shadowRdData,
  input logic             shiftEvt,
  input logic             swapEvt,
  input logic             matchEvt
);

  // R2
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !shiftEvt);

  // R3
  ser_out_on_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> shiftEvt);

  // R4
  swap_with_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapEvt |-> shiftEvt);

  // R6
  shadow_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    shadowWrEn |=> (shadowRdData == $past(shadowWrData)));

  // R7
  match_needs_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(matchModeCfg && matchIrqEn) |=> !matchEvt);

  // R8
  no_swap_in_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchModeCfg && matchIrqEn) |=> !swapEvt);

  // R9
  match_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> !matchEvt);

endmodule

bind shadow_shift_slice slice_chk #(.WIDTH(WIDTH), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_shadow_shift_slice.sv
`timescale 1ns/1ps
module sim_shadow_shift_slice;

  localparam int WIDTH = 32;
  localparam int DIV_W = 12;
  localparam int POS_W = $clog2(WIDTH);
  localparam int NVEC  = 4;

  // {divPreset, shadow word to send, serial word to receive}
  localparam logic [75:0] VEC [NVEC] = '{
    {12'd0, 32'h8000_0001, 32'hDEAD_BEEF},
    {12'd1, 32'hA5A5_5A5A, 32'h0000_FFFF},
    {12'd3, 32'h1234_5678, 32'hC3C3_3C3C},
    {12'd2, 32'hFFFF_0000, 32'h8765_4321}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic [DIV_W-1:0] divPreset;
  logic [POS_W-1:0] posPreset;
  logic             matchModeCfg;
  logic             matchIrqEn;
  logic [WIDTH-1:0] patternMask;
  logic             serIn;
  logic             serOut;
  logic             shadowWrEn;
  logic [WIDTH-1:0] shadowWrData;
  logic [WIDTH-1:0] shadowRdData;
  logic             shiftEvt;
  logic             swapEvt;
  logic             matchEvt;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  shadow_shift_slice #(.WIDTH(WIDTH), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .divPreset(divPreset),
    .posPreset(posPreset), .matchModeCfg(matchModeCfg), .matchIrqEn(matchIrqEn),
    .patternMask(patternMask), .serIn(serIn), .serOut(serOut),
    .shadowWrEn(shadowWrEn), .shadowWrData(shadowWrData),
    .shadowRdData(shadowRdData), .shiftEvt(shiftEvt), .swapEvt(swapEvt),
    .matchEvt(matchEvt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; shadowWrEn = 1'b0; serIn = 1'b0;
    matchModeCfg = 1'b0; matchIrqEn = 1'b0; patternMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeShadow(input logic [31:0] v);
    @(negedge clk);
    shadowWrEn = 1'b1; shadowWrData = v;
    @(negedge clk);
    shadowWrEn = 1'b0;
  endtask

  task automatic countMatch(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (matchEvt) cnt++;
    end
  endtask

  initial begin
    int mcnt;
    int scnt;
    logic [31:0] pat;
    rstN = 1'b0; enable = 1'b0; divPreset = '0; posPreset = '0;
    matchModeCfg = 1'b0; matchIrqEn = 1'b0; patternMask = '0;
    serIn = 1'b0; shadowWrEn = 1'b0; shadowWrData = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 serOut", serOut, 0);
    check("R1 shiftEvt", shiftEvt, 0);
    check("R1 swapEvt", swapEvt, 0);
    check("R1 matchEvt", matchEvt, 0);
    check("R1 shadowRdData", shadowRdData, 0);
    rstN = 1'b1;

    // R2: no strikes while enable is low
    divPreset = '0;
    scnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (shiftEvt) scnt++;
    end
    check("R2 no shift while disabled", scnt, 0);

    // Table-driven frames: R2 spacing, R3 shift order, R4 exchange timing, R5 capture
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] dp;
      logic [31:0] sendW;
      logic [31:0] recvW;
      int k;
      int lastCyc;
      int cyc;
      dp = VEC[v][75:64]; sendW = VEC[v][63:32]; recvW = VEC[v][31:0];
      doReset();
      divPreset = dp; posPreset = 5'd31;
      writeShadow(sendW);
      check("R6 shadow readback", shadowRdData, sendW);
      enable = 1'b1;
      k = 0; lastCyc = 0; cyc = 0;
      while (k < 33 && cyc < 2000) begin
        @(negedge clk);
        cyc++;
        if (shiftEvt) begin
          k++;
          if (k >= 2) check("R2 strike spacing", cyc - lastCyc, dp + 1);
          lastCyc = cyc;
          check("R4 swap timing", swapEvt, (k == 1 || k == 33));
          if (k <= 32) begin
            check("R3 serOut bit", serOut, sendW[k-1]);
            serIn = recvW[k-1];
          end
        end else begin
          check("R4 swap only with shift", swapEvt, 0);
        end
      end
      enable = 1'b0;
      check("R4 frame completed", k, 33);
      check("R5 captured word", shadowRdData, recvW);
    end

    // R6: write on the same edge as an exchange wins
    doReset();
    divPreset = '0; posPreset = '0;
    writeShadow(32'h1111_2222);
    @(negedge clk);
    enable = 1'b1; shadowWrEn = 1'b1; shadowWrData = 32'hCAFE_F00D;
    @(negedge clk);
    enable = 1'b0; shadowWrEn = 1'b0;
    check("R6 exchange happened", swapEvt, 1);
    check("R6 write priority", shadowRdData, 32'hCAFE_F00D);
    check("R5 data took old shadow (lsb)", serOut, 1'b0);

    // R7: configuration bit alone keeps normal exchanges, no match event
    doReset();
    divPreset = '0; posPreset = '0;
    matchModeCfg = 1'b1;
    enable = 1'b1;
    scnt = 0; mcnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (swapEvt) scnt++;
      if (matchEvt) mcnt++;
    end
    enable = 1'b0;
    check("R7 cfg only swaps", scnt, 10);
    check("R7 cfg only no match", mcnt, 0);
    // R7: enable bit alone also leaves match inactive
    matchModeCfg = 1'b0; matchIrqEn = 1'b1;
    countMatch(5, mcnt);
    check("R7 enable only no match", mcnt, 0);

    // R8, R9: pattern match, shadow preserved, one pulse
    doReset();
    pat = 32'hA5C3_1E77;
    writeShadow(pat);
    matchModeCfg = 1'b1; matchIrqEn = 1'b1;
    divPreset = 12'd1; posPreset = 5'd31;
    serIn = pat[0];
    enable = 1'b1;
    begin
      int k;
      int cyc;
      k = 0; cyc = 0; mcnt = 0; scnt = 0;
      while (k < 32 && cyc < 500) begin
        @(negedge clk);
        cyc++;
        if (matchEvt) mcnt++;
        if (swapEvt) scnt++;
        if (shiftEvt) begin
          k++;
          if (k < 32) serIn = pat[k];
          else enable = 1'b0;
        end
      end
    end
    countMatch(10, scnt == 0 ? mcnt : mcnt);
    begin
      int extra;
      countMatch(10, extra);
      check("R9 steady match no repeat", extra, 0);
    end
    check("R9 single match pulse", mcnt, 1);
    check("R8 no exchange in match mode", scnt, 0);
    check("R8 shadow keeps pattern", shadowRdData, pat);

    // R10: mask removes bits from the comparison
    writeShadow(~pat);
    countMatch(3, mcnt);
    check("R9 mismatch no pulse", mcnt, 0);
    writeShadow(pat ^ 32'hFFFF_0000);
    countMatch(4, mcnt);
    check("R10 unmasked difference no match", mcnt, 0);
    @(negedge clk);
    patternMask = 32'hFFFF_0000;
    countMatch(4, mcnt);
    check("R10 masked difference matches", mcnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule